// File: doc/BRIEF.md
# NAND Flash Device Bus Front End

This block is the device side of a byte-wide NAND flash bus. The host moves the chip-select, command-latch, address-latch, write-strobe, read-strobe, write-protect and spare-enable lines. The block samples these lines in its own system clock domain and detects their edges. Each write strobe routes the byte on the bus to the command decoder, to the address collector or to a page buffer. Each read strobe puts one page-buffer byte on the bus and steps a column counter. A pull-low output reports ready/busy.

The memory array is not part of this block. A single page buffer stands in for it, and busy periods come from parameters. Program keeps the buffered bytes. Erase refills the buffer with 0xFF. Read makes the buffer readable after a busy period. Chip deselect is ignored while a program or erase runs. It ends a read at once. Write protect stops program and erase from starting. The spare enable extends the column range beyond the main area.

Top module: `nand_bus_front`

## Requirements
- R1: After reset, rb_low, io_oe and op_done are 0 and the page buffer holds 0xFF in every column.
- R2: A rising write strobe with ce_n low, cle high and ale low latches a command. The codes are 0x00 (read), 0x80 (program load), 0x10 (program confirm), 0x60 (erase setup), 0xD0 (erase confirm) and 0xFF (return to idle, which ends a read-out phase). Other codes are ignored.
- R3: A rising write strobe with ale high and cle low latches an address byte. After 0x00 or 0x80, one column byte comes first and then ROW_BYTES row bytes. After 0x60, only row bytes follow. The column counter takes the column byte when the last row byte arrives. A column byte above the last spare column loads 0.
- R4: In the program-load phase, a rising write strobe with cle and ale both low writes the byte into the page buffer at the column counter, and the counter then advances.
- R5: In the read-out phase, a falling read strobe puts the buffer byte at the column counter on io_out and advances the counter. io_oe is 1 while the read strobe stays low. Both take effect three clock edges after the pin changes.
- R6: io_oe is 0 whenever ce_n is high and outside the read-out phase.
- R7: rb_low is 1 for exactly PROG_CYC, ERASE_CYC or READ_CYC cycles after a program confirm, an erase confirm or the last read address byte. op_done pulses for one cycle when that period completes.
- R8: A completed erase sets every page-buffer column to 0xFF.
- R9: With wp_n low, 0x10 and 0xD0 start nothing: no busy, no op_done, the buffer is unchanged, and the block returns to idle.
- R10: ce_n high during a read busy period or the read-out phase ends the read. rb_low is released with no op_done, and later read strobes drive nothing.
- R11: ce_n high during a program or erase busy period has no effect, and the full period and op_done still occur.
- R12: The column counter wraps to 0 after column MAIN_COLS-1 when spare_en is low, and after column MAIN_COLS+SPARE_COLS-1 when spare_en is high.
- R13: Write and read strobes are ignored while ce_n is high and while rb_low is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the shortest strobe pulse rate |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| cle | input | 1 | Command latch enable, asynchronous |
| ale | input | 1 | Address latch enable, asynchronous |
| we_n | input | 1 | Write strobe, latches on rising edge, asynchronous |
| re_n | input | 1 | Read strobe, drives on falling edge, asynchronous |
| wp_n | input | 1 | Write protect, active low, asynchronous |
| spare_en | input | 1 | Extends column range into the spare area |
| io_in | input | 8 | Bus byte from host |
| io_out | output | 8 | Bus byte to host, valid when io_oe is 1 |
| io_oe | output | 1 | Bus drive enable; 0 models high impedance |
| rb_low | output | 1 | 1 pulls the ready/busy line low (busy), 0 releases it |
| op_done | output | 1 | One-cycle pulse at completion of program, erase or read |

## Verification
A wrong column counter or a stale page-buffer entry appears as a wrong io_out byte on the very next read strobe. A random program-then-read model exposes it within one read-out burst, including bursts that wrap at either range end. A wrong phase in the command sequencer shows up as a missing or extra busy period at the next confirm, or as io_oe failing to rise three edges after a read strobe. Busy periods are counted cycle by cycle at the pins, so an off-by-one timer or a missed chip-select hold shows on the first operation it affects.

// File: rtl/nfb_pkg.sv
// Shared types and command codes for the NAND bus front end.
// Assumes an 8-bit bus; codes are compared against the synchronised byte.
package nfb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PDATA,
        ST_ECONF,
        ST_BUSY,
        ST_RDOUT
    } fe_state_t;

    typedef enum logic [1:0] {
        OP_READ,
        OP_PROG,
        OP_ERASE
    } op_kind_t;

    localparam logic [7:0] CMD_READ   = 8'h00;
    localparam logic [7:0] CMD_PLOAD  = 8'h80;
    localparam logic [7:0] CMD_PCONF  = 8'h10;
    localparam logic [7:0] CMD_ESETUP = 8'h60;
    localparam logic [7:0] CMD_ECONF  = 8'hD0;
    localparam logic [7:0] CMD_RESET  = 8'hFF;
endpackage

// File: rtl/nfb_sync.sv
// Two-flop synchroniser, one chain per bit.
// Assumes each input stays stable for at least two clock periods; the reset
// value of each bit comes from INIT so that idle-high strobes start inactive.
module nfb_sync #(
    parameter int           W    = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            logic s1;
            logic s2;
            // bring bit i into the clock domain through two stages
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1 <= INIT[i];
                    s2 <= INIT[i];
                end else begin
                    s1 <= d[i];
                    s2 <= s1;
                end
            end
            assign q[i] = s2;
        end
    endgenerate
endmodule

// File: rtl/nfb_page_buf.sv
// Page buffer standing in for the array: one write port, one combinational
// read port, and a whole-page fill to 0xFF used by erase and reset.
// Assumes addresses beyond DEPTH-1 are never written; such reads return 0xFF.
module nfb_page_buf #(
    parameter int DEPTH = 20,
    parameter int DW    = 8,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          fill,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];

    // storage update: fill on reset or erase, otherwise single-byte write
    always_ff @(posedge clk) begin
        if (!rst_n || fill) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '1;
        end else if (wr_en && wr_addr <= LAST) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // read port with out-of-range guard
    always_comb begin
        rd_data = (rd_addr <= LAST) ? mem[rd_addr] : '1;
    end

    // R8
    fill_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill |=> (mem[0] == '1 && mem[DEPTH-1] == '1));

    // R4
    wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !fill && wr_addr <= LAST) |=> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/nfb_ctrl.sv
// Command, address and data sequencer with column counter and busy timer.
// Takes synchronised strobe levels and detects edges itself. Assumes the bus
// byte is stable for three clocks around each write strobe rising edge.
module nfb_ctrl
    import nfb_pkg::*;
#(
    parameter int MAIN_COLS  = 16,
    parameter int SPARE_COLS = 4,
    parameter int ROW_BYTES  = 2,
    parameter int PROG_CYC   = 20,
    parameter int ERASE_CYC  = 30,
    parameter int READ_CYC   = 10,
    parameter int CW         = $clog2(MAIN_COLS + SPARE_COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n_s,
    input  logic          cle_s,
    input  logic          ale_s,
    input  logic          we_n_s,
    input  logic          re_n_s,
    input  logic          wp_n_s,
    input  logic          se_s,
    input  logic [7:0]    io_s,
    input  logic [7:0]    rd_data,
    output logic          buf_wr_en,
    output logic          buf_fill,
    output logic [CW-1:0] col,
    output logic [7:0]    dout,
    output logic          oe,
    output logic          rb_low,
    output logic          done
);
    localparam int TOTAL   = MAIN_COLS + SPARE_COLS;
    localparam int MAX_AB  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int MAX_CYC = (MAX_AB > READ_CYC) ? MAX_AB : READ_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int ACW     = $clog2(ROW_BYTES + 1);
    localparam logic [CW-1:0] LAST_MAIN = CW'(MAIN_COLS - 1);
    localparam logic [CW-1:0] LAST_ALL  = CW'(TOTAL - 1);
    localparam logic [7:0]    LAST_B    = 8'(TOTAL - 1);

    fe_state_t        state;
    op_kind_t         kind;
    logic [ACW-1:0]   addr_cnt;
    logic [CW-1:0]    col_hold;
    logic [CNT_W-1:0] cnt;
    logic             we_prev;
    logic             re_prev;

    logic             wr_stb, cmd_stb, adr_stb, dat_stb, rd_stb;
    logic [CW-1:0]    col_last, col_inc;

    // edge history of the two strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_prev <= 1'b1;
            re_prev <= 1'b1;
        end else begin
            we_prev <= we_n_s;
            re_prev <= re_n_s;
        end
    end

    // strobe decode and column step
    always_comb begin
        wr_stb   = !ce_n_s && we_n_s && !we_prev;
        cmd_stb  = wr_stb && cle_s && !ale_s;
        adr_stb  = wr_stb && ale_s && !cle_s;
        dat_stb  = wr_stb && !ale_s && !cle_s;
        rd_stb   = !ce_n_s && !re_n_s && re_prev;
        col_last = se_s ? LAST_ALL : LAST_MAIN;
        col_inc  = (col >= col_last) ? '0 : col + 1'b1;
    end

    // sequencer: phases, column counter, busy timer, read data register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            kind     <= OP_READ;
            addr_cnt <= '0;
            col      <= '0;
            col_hold <= '0;
            cnt      <= '0;
            dout     <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_BUSY) begin
                if (kind == OP_READ && ce_n_s) begin
                    state <= ST_IDLE;
                end else if (cnt == '0) begin
                    done  <= 1'b1;
                    state <= (kind == OP_READ) ? ST_RDOUT : ST_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (ce_n_s) begin
                if (state == ST_RDOUT) state <= ST_IDLE;
            end else if (cmd_stb) begin
                case (io_s)
                    CMD_RESET: state <= ST_IDLE;
                    CMD_READ: begin
                        state    <= ST_ADDR;
                        kind     <= OP_READ;
                        addr_cnt <= '0;
                    end
                    CMD_PLOAD: begin
                        state    <= ST_ADDR;
                        kind     <= OP_PROG;
                        addr_cnt <= '0;
                    end
                    CMD_ESETUP: begin
                        state    <= ST_ADDR;
                        kind     <= OP_ERASE;
                        addr_cnt <= ACW'(1);
                    end
                    CMD_PCONF: begin
                        if (state == ST_PDATA) begin
                            state <= wp_n_s ? ST_BUSY : ST_IDLE;
                            cnt   <= CNT_W'(PROG_CYC - 1);
                        end
                    end
                    CMD_ECONF: begin
                        if (state == ST_ECONF) begin
                            state <= wp_n_s ? ST_BUSY : ST_IDLE;
                            cnt   <= CNT_W'(ERASE_CYC - 1);
                        end
                    end
                    default: ;
                endcase
            end else if (adr_stb && state == ST_ADDR) begin
                if (addr_cnt == '0)
                    col_hold <= (io_s <= LAST_B) ? io_s[CW-1:0] : '0;
                if (addr_cnt == ACW'(ROW_BYTES)) begin
                    col <= col_hold;
                    case (kind)
                        OP_READ: begin
                            state <= ST_BUSY;
                            cnt   <= CNT_W'(READ_CYC - 1);
                        end
                        OP_PROG:  state <= ST_PDATA;
                        default:  state <= ST_ECONF;
                    endcase
                end else begin
                    addr_cnt <= addr_cnt + 1'b1;
                end
            end else if (dat_stb && state == ST_PDATA) begin
                col <= col_inc;
            end else if (rd_stb && state == ST_RDOUT) begin
                dout <= rd_data;
                col  <= col_inc;
            end
        end
    end

    // bus drive enable follows the read strobe level in the read-out phase
    always_ff @(posedge clk) begin
        if (!rst_n) oe <= 1'b0;
        else        oe <= (state == ST_RDOUT) && !ce_n_s && !re_n_s;
    end

    // buffer control and busy indication
    always_comb begin
        buf_wr_en = dat_stb && (state == ST_PDATA);
        buf_fill  = (state == ST_BUSY) && (kind == OP_ERASE) && (cnt == '0);
        rb_low    = (state == ST_BUSY);
    end

    // checker-side run length of the busy indication
    logic [CNT_W:0] chk_run;
    always_ff @(posedge clk) begin
        if (!rst_n)      chk_run <= '0;
        else if (rb_low) chk_run <= chk_run + 1'b1;
        else             chk_run <= '0;
    end

    function automatic int len_of(op_kind_t k);
        return (k == OP_PROG) ? PROG_CYC : (k == OP_ERASE) ? ERASE_CYC : READ_CYC;
    endfunction

    // R7
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(chk_run) == len_of(kind)));

    // R6
    oe_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> $past(!ce_n_s && state == ST_RDOUT));

    // R11
    pe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && kind != OP_READ && cnt != '0) |=> (state == ST_BUSY));

    // R9
    wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rb_low) && kind != OP_READ) |-> $past(wp_n_s));

    // R12
    col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col <= LAST_ALL);

    // R13
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_low |-> (!oe && !buf_wr_en));
endmodule

// File: rtl/nand_bus_front.sv
// Top of the NAND bus front end: synchronises the pins, runs the sequencer
// and holds the page buffer. Assumes clk is at least four times faster than
// the shortest strobe pulse and that io_in is stable around write strobes.
module nand_bus_front #(
    parameter int MAIN_COLS  = 16,
    parameter int SPARE_COLS = 4,
    parameter int ROW_BYTES  = 2,
    parameter int PROG_CYC   = 20,
    parameter int ERASE_CYC  = 30,
    parameter int READ_CYC   = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic       wp_n,
    input  logic       spare_en,
    input  logic [7:0] io_in,
    output logic [7:0] io_out,
    output logic       io_oe,
    output logic       rb_low,
    output logic       op_done
);
    localparam int TOTAL = MAIN_COLS + SPARE_COLS;
    localparam int CW    = $clog2(TOTAL);

    logic [6:0]    pins_s;
    logic [7:0]    io_s;
    logic [7:0]    rd_data;
    logic [CW-1:0] col;
    logic          buf_wr_en, buf_fill;

    nfb_sync #(.W(7), .INIT(7'b1001100)) u_pin_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ce_n, cle, ale, we_n, re_n, wp_n, spare_en}),
        .q(pins_s)
    );

    nfb_sync #(.W(8), .INIT(8'h00)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d(io_in), .q(io_s)
    );

    nfb_ctrl #(
        .MAIN_COLS(MAIN_COLS), .SPARE_COLS(SPARE_COLS), .ROW_BYTES(ROW_BYTES),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .READ_CYC(READ_CYC), .CW(CW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ce_n_s(pins_s[6]), .cle_s(pins_s[5]), .ale_s(pins_s[4]),
        .we_n_s(pins_s[3]), .re_n_s(pins_s[2]), .wp_n_s(pins_s[1]),
        .se_s(pins_s[0]), .io_s(io_s), .rd_data(rd_data),
        .buf_wr_en(buf_wr_en), .buf_fill(buf_fill), .col(col),
        .dout(io_out), .oe(io_oe), .rb_low(rb_low), .done(op_done)
    );

    nfb_page_buf #(.DEPTH(TOTAL), .DW(8), .AW(CW)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(buf_wr_en), .wr_addr(col), .wr_data(io_s),
        .fill(buf_fill), .rd_addr(col), .rd_data(rd_data)
    );
endmodule

// File: tb/nand_bus_front_bench.sv
module nand_bus_front_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAIN = 16, SPARE = 4, PROG = 20, ERASE = 30, RDC = 10;

    logic clk = 0, rst_n = 0;
    logic ce_n = 1, cle = 0, ale = 0, we_n = 1, re_n = 1, wp_n = 1, spare_en = 0;
    logic [7:0] io_in = 0, io_out;
    logic io_oe, rb_low, op_done;

    int total = 0, bad = 0, busy_cnt = 0, done_cnt = 0, finished = 0;
    logic [7:0] exp_mem [MAIN+SPARE];

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_bus_front u_nand_bus_front (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .wp_n(wp_n), .spare_en(spare_en), .io_in(io_in),
        .io_out(io_out), .io_oe(io_oe), .rb_low(rb_low), .op_done(op_done)
    );

    always @(negedge clk) begin
        if (rb_low)  busy_cnt <= busy_cnt + 1;
        if (op_done) done_cnt <= done_cnt + 1;
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int next_col(int c, logic sp);
        int last = sp ? MAIN + SPARE - 1 : MAIN - 1;
        return (c >= last) ? 0 : c + 1;
    endfunction

    task automatic wr_cycle(logic c, logic a, logic [7:0] b);
        io_in = b; cle = c; ale = a; tick(1);
        we_n = 0; tick(4); we_n = 1; tick(4);
        cle = 0; ale = 0;
    endtask

    task automatic rd_cycle(output logic [7:0] d, output logic oe);
        re_n = 0; tick(4);
        d = io_out; oe = io_oe;
        re_n = 1; tick(4);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 200 && rb_low; i++) tick(1);
        tick(2);
    endtask

    task automatic addr_seq(int col);
        wr_cycle(0, 1, 8'(col));
        wr_cycle(0, 1, 8'h5A);
        wr_cycle(0, 1, 8'h01);
    endtask

    task automatic prog_seq(int start, int n, logic sp);
        int c = start;
        int b0, d0;
        logic [7:0] d;
        spare_en = sp; tick(3);
        wr_cycle(1, 0, 8'h80);
        addr_seq(start);
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            wr_cycle(0, 0, d);
            exp_mem[c] = d;
            c = next_col(c, sp);
        end
        b0 = busy_cnt; d0 = done_cnt;
        wr_cycle(1, 0, 8'h10);
        wait_ready();
        chk("R7 program busy", busy_cnt - b0, PROG);
        chk("R7 program done", done_cnt - d0, 1);
    endtask

    task automatic read_seq(int start, int n, logic sp, string tag);
        int c = start;
        int b0, d0;
        logic [7:0] d;
        logic oe;
        spare_en = sp; tick(3);
        wr_cycle(1, 0, 8'h00);
        b0 = busy_cnt; d0 = done_cnt;
        addr_seq(start);
        wait_ready();
        chk("R7 read busy", busy_cnt - b0, RDC);
        chk("R7 read done", done_cnt - d0, 1);
        for (int i = 0; i < n; i++) begin
            rd_cycle(d, oe);
            chk({tag, " R5 oe"}, int'(oe), 1);
            chk({tag, " data"}, int'(d), int'(exp_mem[c]));
            c = next_col(c, sp);
        end
        chk("R6 oe released", int'(io_oe), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (finished == 0) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int b0, d0;
        logic [7:0] d;
        logic oe;
        void'($urandom(32'h5EED));
        for (int i = 0; i < MAIN + SPARE; i++) exp_mem[i] = 8'hFF;
        tick(5);
        rst_n = 1; tick(3);
        // R1 reset state
        chk("R1 rb_low", int'(rb_low), 0);
        chk("R1 io_oe", int'(io_oe), 0);
        chk("R1 op_done", int'(op_done), 0);
        ce_n = 0; tick(3);
        read_seq(0, 2, 0, "R1 erased buffer");

        // R2 R3 R4 R5 directed program then read
        prog_seq(3, 5, 0);
        read_seq(3, 5, 0, "R3 R4 directed");

        // R12 wrap with spare enabled and disabled
        prog_seq(18, 4, 1);
        read_seq(18, 4, 1, "R12 spare wrap");
        prog_seq(14, 3, 0);
        read_seq(14, 3, 0, "R12 main wrap");
        read_seq(15, 2, 1, "R12 spare continue");

        // random program and read-back rounds
        for (int r = 0; r < 6; r++) begin
            logic sp = 1'($urandom);
            int st = sp ? int'($urandom_range(19, 0)) : int'($urandom_range(15, 0));
            int n = int'($urandom_range(8, 1));
            prog_seq(st, n, sp);
            read_seq(st, n, sp, "R4 R5 random");
        end

        // R9 write protect blocks erase and program
        spare_en = 0; wp_n = 0; tick(3);
        b0 = busy_cnt; d0 = done_cnt;
        wr_cycle(1, 0, 8'h60);
        wr_cycle(0, 1, 8'h5A);
        wr_cycle(0, 1, 8'h01);
        wr_cycle(1, 0, 8'hD0);
        tick(4);
        wr_cycle(1, 0, 8'h80);
        addr_seq(0);
        wr_cycle(1, 0, 8'h10);
        tick(4);
        chk("R9 no busy", busy_cnt - b0, 0);
        chk("R9 no done", done_cnt - d0, 0);
        wp_n = 1; tick(3);
        read_seq(3, 2, 0, "R9 buffer kept");

        // R8 erase fills buffer
        b0 = busy_cnt; d0 = done_cnt;
        wr_cycle(1, 0, 8'h60);
        wr_cycle(0, 1, 8'h5A);
        wr_cycle(0, 1, 8'h01);
        wr_cycle(1, 0, 8'hD0);
        wait_ready();
        chk("R7 erase busy", busy_cnt - b0, ERASE);
        chk("R7 erase done", done_cnt - d0, 1);
        for (int i = 0; i < MAIN + SPARE; i++) exp_mem[i] = 8'hFF;
        read_seq(0, 4, 0, "R8 erased");
        read_seq(17, 3, 1, "R8 erased spare");

        // R11 deselect during program busy is ignored
        spare_en = 0; tick(3);
        wr_cycle(1, 0, 8'h80);
        addr_seq(6);
        wr_cycle(0, 0, 8'hA5);
        exp_mem[6] = 8'hA5;
        b0 = busy_cnt; d0 = done_cnt;
        wr_cycle(1, 0, 8'h10);
        ce_n = 1; tick(6); ce_n = 0;
        wait_ready();
        chk("R11 full busy", busy_cnt - b0, PROG);
        chk("R11 done", done_cnt - d0, 1);
        read_seq(6, 1, 0, "R11 data");

        // R10 deselect during read busy aborts
        wr_cycle(1, 0, 8'h00);
        b0 = busy_cnt; d0 = done_cnt;
        addr_seq(6);
        ce_n = 1; tick(8);
        chk("R10 busy cut short", int'((busy_cnt - b0) < RDC), 1);
        chk("R10 no done", done_cnt - d0, 0);
        chk("R10 released", int'(rb_low), 0);
        ce_n = 0; tick(3);
        rd_cycle(d, oe);
        chk("R10 no drive after abort", int'(oe), 0);

        // R10 deselect during read-out phase
        wr_cycle(1, 0, 8'h00);
        addr_seq(6);
        wait_ready();
        rd_cycle(d, oe);
        chk("R10 first byte", int'(d), int'(exp_mem[6]));
        ce_n = 1; tick(4);
        re_n = 0; tick(4);
        chk("R6 no drive while deselected", int'(io_oe), 0);
        re_n = 1; ce_n = 0; tick(4);
        rd_cycle(d, oe);
        chk("R10 read-out ended", int'(oe), 0);

        // R2 reset command ends read-out
        wr_cycle(1, 0, 8'h00);
        addr_seq(6);
        wait_ready();
        wr_cycle(1, 0, 8'hFF);
        rd_cycle(d, oe);
        chk("R2 reset command ends read", int'(oe), 0);

        // R13 write strobe ignored while deselected
        wr_cycle(1, 0, 8'h80);
        addr_seq(2);
        b0 = busy_cnt;
        ce_n = 1; tick(3);
        wr_cycle(1, 0, 8'h10);
        tick(4);
        chk("R13 deselected confirm ignored", busy_cnt - b0, 0);
        ce_n = 0; tick(3);
        d0 = done_cnt;
        wr_cycle(1, 0, 8'h10);
        wait_ready();
        chk("R13 confirm after select", done_cnt - d0, 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule